// File: doc/BRIEF.md
# External DMA Request Handshake Controller

This block sits between an external device and a four-channel DMA engine while the engine runs in its data-bus handshake mode. The device raises a bus-release request. The block then grants the shared data bus by raising a bus-available flag. Exactly two cycles after the grant begins, it samples the transfer-request line once. If that line is high, the block looks at the release request in the same cycle to classify the request. A lone transfer request is a normal request, and the channel comes from the descriptor the device drives on the bus. Transfer request and release request together form a direct request, which is always routed to one fixed channel.

A serviced request produces three things in the same single cycle: an acknowledge strobe back to the device, a two-bit channel number, and a one-cycle pulse on the internal request line of the selected channel. Address generation, transfer counting, data movement and the register file belong to other blocks.

Top module: `dma_hs_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is low in the following cycle. Reset is synchronous and active low.
- R2: If `bus_rel_req_i` is high at a clock edge while the block is idle, `bus_avail_o` goes high in the next cycle.
- R3: `bus_avail_o` stays high for exactly three consecutive cycles. The third of those cycles is the only sample cycle.
- R4: In the sample cycle, `xfer_req_i` high with `bus_rel_req_i` low is a normal request. It is serviced on channel `bus_data_i[1:0]` (value 0 to 3), with the acknowledge in the cycle after the sample cycle.
- R5: In the sample cycle, `xfer_req_i` and `bus_rel_req_i` both high form a direct request. It is serviced on channel 2 whatever `bus_data_i` holds.
- R6: If `xfer_req_i` is low in the sample cycle, no acknowledge follows, `bus_avail_o` drops and the block returns to idle.
- R7: `xfer_req_i` in any cycle other than the sample cycle produces no acknowledge.
- R8: `ack_o` is one cycle wide. `chan_id_o` carries the serviced channel while `ack_o` is high and is zero otherwise.
- R9: `chan_req_o` is a one-hot pulse, with bit n set for channel n, in exactly the cycle where `ack_o` is high. Otherwise it is all zero.
- R10: `bus_rel_req_i` is ignored from the grant until the acknowledge cycle, inclusive. `bus_avail_o` is low during the acknowledge cycle. A release request held high re-grants the bus two cycles after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rel_req_i | input | 1 | Bus-release request from the external device |
| xfer_req_i | input | 1 | Transfer request from the external device |
| bus_data_i | input | 32 | Data bus; carries the request descriptor in the sample cycle |
| bus_avail_o | output | 1 | Data bus granted to the external device |
| ack_o | output | 1 | One-cycle acknowledge strobe to the device |
| chan_id_o | output | 2 | Serviced channel number, valid with `ack_o` |
| chan_req_o | output | 4 | One-hot request pulse to the DMA channels |

## Verification
A release request seen at edge k raises `bus_avail_o` one cycle later and holds it for three cycles. The transfer request is examined at the edge that ends the third cycle. The acknowledge, channel number and one-hot pulse all appear one cycle after that edge, so they arrive four cycles after the release request. The bench model works out each of these due cycles from a phase counter that it advances at every rising edge, using the inputs present at that edge. Every output is compared on the following falling edge, so each check reads exactly the cycle in which the result is due.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;

    // Handshake phases of the grant sequencer
    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_GRANT = 2'd1,
        HS_ACK   = 2'd2
    } hs_state_e;

endpackage

// File: rtl/dma_hs_grant_fsm.sv
module dma_hs_grant_fsm
    import dma_hs_pkg::*;
#(
    parameter int GRANT_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rel_req_i,
    input  logic xfer_req_i,
    output logic bus_avail_o,
    output logic sample_o,
    output logic in_ack_o
);

    localparam int CNT_W = (GRANT_LAT < 1) ? 1 : $clog2(GRANT_LAT + 1);
    localparam logic [CNT_W-1:0] LAT_C = CNT_W'(GRANT_LAT);

    typedef struct packed {
        hs_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic             avail;
    } fsm_reg_t;

    localparam fsm_reg_t FSM_RST = '{st: HS_IDLE, cnt: '0, avail: 1'b0};

    fsm_reg_t fsm_d, fsm_q;
    logic     at_window;

    assign at_window = (fsm_q.st == HS_GRANT) && (fsm_q.cnt == LAT_C);

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            HS_IDLE: begin
                if (rel_req_i) begin
                    fsm_d.st    = HS_GRANT;
                    fsm_d.cnt   = '0;
                    fsm_d.avail = 1'b1;
                end
            end
            HS_GRANT: begin
                if (at_window) begin
                    fsm_d.avail = 1'b0;
                    fsm_d.cnt   = '0;
                    fsm_d.st    = xfer_req_i ? HS_ACK : HS_IDLE;
                end else begin
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                end
            end
            HS_ACK: begin
                fsm_d.st = HS_IDLE;
            end
            default: fsm_d = FSM_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fsm_q <= FSM_RST;
        else        fsm_q <= fsm_d;
    end

    assign bus_avail_o = fsm_q.avail;
    assign sample_o    = at_window;
    assign in_ack_o    = (fsm_q.st == HS_ACK);

    // Grant only follows a release request seen while idle
    assert_grant_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_avail_o) |-> $past(rel_req_i));

    // The sample cycle lies inside the bus-available window
    assert_window_in_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> bus_avail_o);

    // No transfer request in the window: the grant is withdrawn
    assert_abandon_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_o && !xfer_req_i) |=> (!bus_avail_o && !in_ack_o));

    // The acknowledge phase never overlaps the grant
    assert_ack_phase_no_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_ack_o |-> !bus_avail_o);

endmodule

// File: rtl/dma_hs_decode.sv
module dma_hs_decode #(
    parameter int NUM_CH    = 4,
    parameter int DESC_W    = 32,
    parameter int DIRECT_CH = 2,
    parameter int ID_W      = $clog2(NUM_CH)
) (
    input  logic              sample_i,
    input  logic              rel_req_i,
    input  logic              xfer_req_i,
    input  logic [DESC_W-1:0] desc_i,
    output logic              hit_o,
    output logic              direct_o,
    output logic [ID_W-1:0]   chan_o
);

    localparam logic [ID_W-1:0] DIRECT_ID = ID_W'(DIRECT_CH);

    logic [ID_W-1:0] desc_chan;
    logic            unused_desc_hi;

    assign desc_chan      = desc_i[ID_W-1:0];
    assign unused_desc_hi = ^desc_i[DESC_W-1:ID_W];

    always_comb begin
        hit_o    = sample_i && xfer_req_i;
        direct_o = hit_o && rel_req_i;
        chan_o   = '0;
        if (hit_o) begin
            chan_o = direct_o ? DIRECT_ID : desc_chan;
        end
    end

endmodule

// File: rtl/dma_hs_ack_drv.sv
module dma_hs_ack_drv #(
    parameter int NUM_CH = 4,
    parameter int ID_W   = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_i,
    input  logic [ID_W-1:0]   chan_i,
    output logic              ack_o,
    output logic [ID_W-1:0]   chan_id_o,
    output logic [NUM_CH-1:0] chan_req_o
);

    typedef struct packed {
        logic              ack;
        logic [ID_W-1:0]   id;
        logic [NUM_CH-1:0] req;
    } ack_reg_t;

    ack_reg_t ack_d, ack_q;
    logic [NUM_CH-1:0] sel_vec;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
        assign sel_vec[g] = hit_i && (chan_i == ID_W'(g));
    end

    always_comb begin
        ack_d     = '0;
        ack_d.ack = hit_i;
        ack_d.req = sel_vec;
        if (hit_i) ack_d.id = chan_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ack_q <= '0;
        else        ack_q <= ack_d;
    end

    assign ack_o      = ack_q.ack;
    assign chan_id_o  = ack_q.id;
    assign chan_req_o = ack_q.req;

    assert_ack_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    assert_id_zero_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_o |-> (chan_id_o == '0));

    assert_req_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(chan_req_o) == (ack_o ? 1 : 0));

    assert_req_matches_id_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> chan_req_o[chan_id_o]);

endmodule

// File: rtl/dma_hs_ctrl.sv
module dma_hs_ctrl #(
    parameter int NUM_CH    = 4,
    parameter int DESC_W    = 32,
    parameter int GRANT_LAT = 2,
    parameter int DIRECT_CH = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_rel_req_i,
    input  logic                       xfer_req_i,
    input  logic [DESC_W-1:0]          bus_data_i,
    output logic                       bus_avail_o,
    output logic                       ack_o,
    output logic [$clog2(NUM_CH)-1:0]  chan_id_o,
    output logic [NUM_CH-1:0]          chan_req_o
);

    localparam int ID_W = $clog2(NUM_CH);

    logic            sample;
    logic            in_ack;
    logic            hit;
    logic            direct;
    logic [ID_W-1:0] chan;

    dma_hs_grant_fsm #(
        .GRANT_LAT (GRANT_LAT)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rel_req_i   (bus_rel_req_i),
        .xfer_req_i  (xfer_req_i),
        .bus_avail_o (bus_avail_o),
        .sample_o    (sample),
        .in_ack_o    (in_ack)
    );

    dma_hs_decode #(
        .NUM_CH    (NUM_CH),
        .DESC_W    (DESC_W),
        .DIRECT_CH (DIRECT_CH),
        .ID_W      (ID_W)
    ) u_dec (
        .sample_i   (sample),
        .rel_req_i  (bus_rel_req_i),
        .xfer_req_i (xfer_req_i),
        .desc_i     (bus_data_i),
        .hit_o      (hit),
        .direct_o   (direct),
        .chan_o     (chan)
    );

    dma_hs_ack_drv #(
        .NUM_CH (NUM_CH),
        .ID_W   (ID_W)
    ) u_ack (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_i      (hit),
        .chan_i     (chan),
        .ack_o      (ack_o),
        .chan_id_o  (chan_id_o),
        .chan_req_o (chan_req_o)
    );

    // Acknowledge only one cycle after a window with a transfer request
    assert_ack_after_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> ($past(sample) && $past(xfer_req_i)));

    // A direct request is always serviced on the fixed channel
    assert_direct_fixed_chan_R5: assert property (@(posedge clk) disable iff (!rst_n)
        direct |=> (ack_o && chan_id_o == ID_W'(DIRECT_CH)));

    // The sequencer and the strobe driver agree on the acknowledge cycle
    assert_ack_phase_align_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o == in_ack);

    // Transfer request outside the window never leads to an acknowledge
    assert_no_ack_outside_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample) |=> !ack_o);

endmodule

// File: tb/dma_hs_ctrl_bench.sv
module dma_hs_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rel = 1'b0;
    logic        xfer = 1'b0;
    logic [31:0] data = '0;
    logic        avail;
    logic        ack;
    logic [1:0]  cid;
    logic [3:0]  creq;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req  = "R1";
    bit    done     = 1'b0;

    // reference model state
    int   phase = 0;
    int   m_ch  = 0;
    bit   e_avail = 0;
    bit   e_ack   = 0;
    int   e_id    = 0;
    int   e_req   = 0;

    always #5 clk = ~clk;

    dma_hs_ctrl u_dma_hs_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_rel_req_i (rel),
        .xfer_req_i    (xfer),
        .bus_data_i    (data),
        .bus_avail_o   (avail),
        .ack_o         (ack),
        .chan_id_o     (cid),
        .chan_req_o    (creq)
    );

    // Behavioural model: phase 0 idle, 1..3 bus granted, 4 acknowledge
    always @(posedge clk) begin
        if (!rst_n) begin
            phase = 0;
        end else begin
            case (phase)
                0: if (rel) phase = 1;
                1: phase = 2;
                2: phase = 3;
                3: begin
                    if (xfer) begin
                        m_ch  = rel ? 2 : int'(data[1:0]);
                        phase = 4;
                    end else begin
                        phase = 0;
                    end
                end
                default: phase = 0;
            endcase
        end
        e_avail = (phase >= 1 && phase <= 3);
        e_ack   = (phase == 4);
        e_id    = e_ack ? m_ch : 0;
        e_req   = e_ack ? (1 << m_ch) : 0;
    end

    task automatic check(input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            check("bus_avail", int'(avail), int'(e_avail));
            check("ack", int'(ack), int'(e_ack));
            check("chan_id", int'(cid), e_id);
            check("chan_req", int'(creq), e_req);
        end
    end

    task automatic cyc(input bit r, input bit x, input logic [31:0] d);
        rel  = r;
        xfer = x;
        data = d;
        @(negedge clk);
    endtask

    // release request, two idle cycles, then the sample cycle
    task automatic handshake(input bit r_s, input bit x_s, input logic [31:0] d);
        cyc(1, 0, 32'hFFFF_FFFF);
        cyc(0, 0, 32'h0);
        cyc(0, 0, 32'h0);
        cyc(r_s, x_s, d);
        cyc(0, 0, 32'h0);
        cyc(0, 0, 32'h0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cur_req = "R1";
        cyc(1, 1, 32'h2);
        cyc(1, 1, 32'h2);
        check("reset outputs", int'({avail, ack, cid, creq}), 0);
        rst_n = 1'b1;
        cyc(0, 0, 32'h0);

        cur_req = "R3";
        handshake(0, 1, 32'h0000_0001);

        cur_req = "R4";
        for (int c = 0; c < 4; c++) begin
            handshake(0, 1, {28'hA5C3_F1E, 2'b00, 2'(c)});
        end

        cur_req = "R5";
        handshake(1, 1, 32'h0000_0001);
        handshake(1, 1, 32'hFFFF_FFFF);

        cur_req = "R6";
        handshake(0, 0, 32'h0000_0003);
        handshake(1, 0, 32'h0000_0003);

        cur_req = "R7";
        cyc(1, 0, 32'h1);
        cyc(0, 1, 32'h1);
        cyc(0, 0, 32'h1);
        cyc(0, 0, 32'h1);
        cyc(0, 1, 32'h1);
        cyc(0, 1, 32'h1);
        cyc(0, 0, 32'h0);

        cur_req = "R10";
        cyc(1, 0, 32'h0);
        cyc(1, 0, 32'h0);
        cyc(1, 0, 32'h0);
        cyc(0, 1, 32'h3);
        cyc(1, 0, 32'h0);
        cyc(1, 0, 32'h0);
        cyc(1, 0, 32'h0);
        cyc(1, 1, 32'h0);
        cyc(0, 0, 32'h0);
        cyc(0, 0, 32'h0);

        cur_req = "R8";
        handshake(0, 1, 32'h2);
        cur_req = "R9";
        handshake(0, 1, 32'h3);
        cur_req = "R2";
        cyc(1, 0, 32'h0);
        check("grant next cycle", int'(avail), 1);
        cyc(0, 0, 32'h0);
        cyc(0, 0, 32'h0);
        cyc(0, 0, 32'h0);
        cyc(0, 0, 32'h0);

        cur_req = "R1";
        rst_n = 1'b0;
        cyc(1, 0, 32'h0);
        check("reset mid-run", int'({avail, ack, cid, creq}), 0);
        rst_n = 1'b1;
        cyc(0, 0, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule